// File: doc/BRIEF.md
# Transmit Completion Ring Poster

This block reports finished packet transmissions to the host. Each time a packet has gone out, the transmit engine hands it one completion event carrying an 8-bit buffer-group index. The block records that index in a circular ring of 32-bit words held in host-shared memory. Bit 31 of every ring word is an ownership flag. A set flag means the device may use the word. A clear flag means the host still holds it.

For each event the block first reads the ring word under its write pointer. If the flag is set, it writes a new word: the index in bits 7..0 and every other bit zero, which also hands the word back to the host. It then advances the pointer and raises a completion cause toward the interrupt line. If the flag is clear, it does not stall silently. It sets a sticky error bit, keeps the event, leaves the pointer where it is, and reads the same word again on each retry strobe. The interrupt output is the OR of the two pending causes that are not masked.

The sequencer has five states:
- IDLE: waits for an event.
- FETCH: issues the read of the current ring word.
- AWAIT: waits for the read data.
- POST: issues the write.
- PARKED: the word was host-owned; waits for a retry strobe.

The transitions are:
- IDLE→FETCH when an event is accepted.
- FETCH→AWAIT when the read request is accepted.
- AWAIT→POST when the returned flag is set.
- AWAIT→PARKED when the returned flag is clear.
- POST→IDLE when the write request is accepted.
- PARKED→FETCH on a retry strobe.

Top module: `tx_cpl_ring`

## Requirements
- R1: `evt_ready` is high only in IDLE, so at most one event is in flight at a time. Events are posted in the order they are accepted.
- R2: For every event, the block reads the word at `ring_base + 4*index` before any write for that event. A request holds its address and direction while `mem_req_ready` is low.
- R3: A write is issued only after the read returned bit 31 = 1. The written word is `{1'b0, 23'b0, group[7:0]}`: flag cleared, bits 30..8 zero, index in bits 7..0.
- R4: The ring index starts at 0 after reset. It advances by one after each accepted write and wraps from DEPTH-1 to 0.
- R5: If the read returns bit 31 = 0, no write is issued, the index does not change and the event is held. Each `retry_pulse` re-reads the same word.
- R6: `done_pending` sets after each accepted write and clears on `done_clr`.
- R7: `err_status` sets each time a read returns bit 31 = 0. It stays set until `err_clr` is pulsed. If a set and a clear fall in the same cycle, the set wins.
- R8: `irq` = (`done_pending` & !`done_mask`) | (`err_status` & !`err_mask`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | 32 | Byte address of ring word 0 |
| evt_valid | input | 1 | Completion event present |
| evt_ready | output | 1 | Event accepted this cycle when high with valid |
| evt_group | input | 8 | Buffer-group index of the finished packet |
| retry_pulse | input | 1 | Re-read a host-owned word |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address of the request |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_rdata | input | 32 | Read data |
| done_mask | input | 1 | Masks the completion cause |
| err_mask | input | 1 | Masks the ownership error cause |
| done_clr | input | 1 | Clears the completion cause |
| err_clr | input | 1 | Clears the sticky error bit |
| done_pending | output | 1 | Completion cause pending |
| err_status | output | 1 | Ownership error bit |
| irq | output | 1 | Host interrupt |

## Verification
The assertions assume that the memory returns exactly one read response per accepted read request, and only while the block waits for it. They also assume that `ring_base` stays constant while an event is in flight.

The bench memory model answers one cycle after accepting a read and never sends an unsolicited response. It can insert random-looking ready stalls, and it keeps `ring_base` fixed for the whole run. Host re-arming of ring words and clearing of flags are done only while the block is idle or parked.

// File: rtl/tx_cpl_pkg.sv
package tx_cpl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_AWAIT,
        ST_POST,
        ST_PARKED
    } poster_state_t;

    localparam int FLAG_BIT = 31;

    function automatic logic [31:0] make_entry(input logic [7:0] grp);
        return {1'b0, 23'd0, grp};
    endfunction
endpackage

// File: rtl/tx_cpl_index.sv
module tx_cpl_index #(
    parameter int DEPTH = 256,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (advance) begin
            idx <= (idx == LAST) ? '0 : idx + 1'b1;
        end
    end

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && idx == LAST) |=> (idx == '0)); // R4
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(idx)); // R4
endmodule

// File: rtl/tx_cpl_irq.sv
module tx_cpl_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_done,
    input  logic set_err,
    input  logic clr_done,
    input  logic clr_err,
    input  logic mask_done,
    input  logic mask_err,
    output logic done_pend,
    output logic err_pend,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_pend <= 1'b0;
            err_pend  <= 1'b0;
        end else begin
            if (set_done) begin
                done_pend <= 1'b1;
            end else if (clr_done) begin
                done_pend <= 1'b0;
            end
            if (set_err) begin
                err_pend <= 1'b1;
            end else if (clr_err) begin
                err_pend <= 1'b0;
            end
        end
    end

    always_comb begin
        irq = (done_pend && !mask_done) || (err_pend && !mask_err);
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pend && !clr_err) |=> err_pend); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_err |=> err_pend); // R7
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_done && mask_err) |-> !irq); // R8
endmodule

// File: rtl/tx_cpl_ring.sv
module tx_cpl_ring
    import tx_cpl_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] ring_base,
    input  logic        evt_valid,
    output logic        evt_ready,
    input  logic [7:0]  evt_group,
    input  logic        retry_pulse,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic        mem_req_write,
    output logic [31:0] mem_req_addr,
    output logic [31:0] mem_req_wdata,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_rdata,
    input  logic        done_mask,
    input  logic        err_mask,
    input  logic        done_clr,
    input  logic        err_clr,
    output logic        done_pending,
    output logic        err_status,
    output logic        irq
);
    localparam int PAD_W = 32 - IDX_W - 2;

    poster_state_t    state_q, state_d;
    logic [7:0]       group_q;
    logic [IDX_W-1:0] idx;
    logic             advance;
    logic             set_err;
    logic             rsp_owned;

    always_comb begin
        rsp_owned = mem_rsp_rdata[FLAG_BIT];
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (evt_valid)      state_d = ST_FETCH;
            ST_FETCH:  if (mem_req_ready)  state_d = ST_AWAIT;
            ST_AWAIT:  if (mem_rsp_valid)  state_d = rsp_owned ? ST_POST : ST_PARKED;
            ST_POST:   if (mem_req_ready)  state_d = ST_IDLE;
            ST_PARKED: if (retry_pulse)    state_d = ST_FETCH;
            default:                       state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            group_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && evt_valid) begin
                group_q <= evt_group;
            end
        end
    end

    always_comb begin
        evt_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_FETCH) || (state_q == ST_POST);
        mem_req_write = (state_q == ST_POST);
        mem_req_addr  = ring_base + {{PAD_W{1'b0}}, idx, 2'b00};
        mem_req_wdata = make_entry(group_q);
        advance       = (state_q == ST_POST) && mem_req_ready;
        set_err       = (state_q == ST_AWAIT) && mem_rsp_valid && !rsp_owned;
    end

    tx_cpl_index #(.DEPTH(DEPTH)) u_index (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .idx     (idx)
    );

    tx_cpl_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_done  (advance),
        .set_err   (set_err),
        .clr_done  (done_clr),
        .clr_err   (err_clr),
        .mask_done (done_mask),
        .mask_err  (err_mask),
        .done_pend (done_pending),
        .err_pend  (err_status),
        .irq       (irq)
    );

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_ready) |=> !evt_ready); // R1
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write))); // R2
    AST_ADDR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> ((mem_req_addr - ring_base) < 32'(DEPTH * 4))); // R2
    AST_NO_BLIND_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid && mem_req_write) |->
            $past(mem_rsp_valid && mem_rsp_rdata[FLAG_BIT])); // R3
    AST_PARKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PARKED) |-> (!mem_req_valid && !evt_ready)); // R5
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write && mem_req_ready) |=> done_pending); // R6
endmodule

// File: tb/tx_cpl_ring_tb.sv
module tx_cpl_ring_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam logic [31:0] BASE = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic        evt_ready;
    logic [7:0]  evt_group = '0;
    logic        retry_pulse = 1'b0;
    logic        mem_req_valid, mem_req_write;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        done_mask = 1'b0, err_mask = 1'b0;
    logic        done_clr = 1'b0, err_clr = 1'b0;
    logic        done_pending, err_status, irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_cpl_ring #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .ring_base(BASE),
        .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_group(evt_group),
        .retry_pulse(retry_pulse),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .done_mask(done_mask), .err_mask(err_mask),
        .done_clr(done_clr), .err_clr(err_clr),
        .done_pending(done_pending), .err_status(err_status), .irq(irq)
    );

    int total = 0, bad = 0;
    int reads = 0, writes = 0;
    int exp_idx = 0;
    int cyc = 0;
    bit stall_mode = 1'b0;
    bit finished = 1'b0;
    logic [31:0] ring [DEPTH];
    logic [63:0] expq [$];

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model and scoreboard monitor, acting at the falling edge
    initial begin
        bit          pend = 1'b0;
        logic [31:0] pend_data = '0;
        forever begin
            @(negedge clk);
            cyc++;
            mem_rsp_valid = pend;
            mem_rsp_rdata = pend_data;
            pend = 1'b0;
            mem_req_ready = stall_mode ? ((cyc % 3) != 0) : 1'b1;
            if (rst_n && mem_req_valid && mem_req_ready) begin
                int slot;
                slot = int'((mem_req_addr - BASE) >> 2) % DEPTH;
                if (mem_req_write) begin
                    logic [63:0] e;
                    writes++;
                    if (expq.size() == 0) begin
                        check(0, "R1 unexpected write", {mem_req_addr, mem_req_wdata}, 64'd0);
                    end else begin
                        e = expq.pop_front();
                        check({mem_req_addr, mem_req_wdata} == e, "R3/R4 posted word",
                              {mem_req_addr, mem_req_wdata}, e);
                        check(ring[slot][31] == 1'b1, "R3 write only to device-owned word",
                              64'(ring[slot][31]), 64'd1);
                    end
                    ring[slot] = mem_req_wdata;
                end else begin
                    reads++;
                    pend = 1'b1;
                    pend_data = ring[slot];
                end
            end
        end
    end

    task automatic send(input logic [7:0] g);
        @(negedge clk);
        while (!evt_ready) @(negedge clk);
        expq.push_back({BASE + 32'(exp_idx * 4), {1'b0, 23'd0, g}});
        exp_idx = (exp_idx + 1) % DEPTH;
        evt_valid = 1'b1;
        evt_group = g;
        @(posedge clk);
        #1;
        evt_valid = 1'b0;
        @(negedge clk);
        check(evt_ready == 1'b0, "R1 busy after accept", 64'(evt_ready), 64'd0);
    endtask

    task automatic wait_posts(input int target);
        while (writes < target) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_done_clr();
        @(negedge clk); done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
    endtask

    task automatic pulse_err_clr();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    task automatic pulse_retry();
        @(negedge clk); retry_pulse = 1'b1;
        @(negedge clk); retry_pulse = 1'b0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
        end
    end

    initial begin
        int w0, r0;
        for (int i = 0; i < DEPTH; i++) ring[i] = 32'h8000_0000;
        repeat (3) @(negedge clk);
        check(evt_ready == 1'b1 && mem_req_valid == 1'b0, "R1 reset idle",
              {62'd0, evt_ready, mem_req_valid}, 64'h2);
        check({done_pending, err_status, irq} == 3'b000, "R6/R7/R8 reset clear",
              64'({done_pending, err_status, irq}), 64'd0);
        rst_n = 1'b1;

        // R1 R3 R4: in-order posting from index 0
        send(8'h11);
        wait_posts(1);
        check(done_pending == 1'b1, "R6 done set", 64'(done_pending), 64'd1);
        check(irq == 1'b1, "R8 irq from done", 64'(irq), 64'd1);
        check(ring[0] == 32'h0000_0011, "R3 flag cleared in memory", 64'(ring[0]), 64'h11);
        send(8'h22); wait_posts(2);
        send(8'h33); wait_posts(3);
        pulse_done_clr();
        @(negedge clk);
        check(done_pending == 1'b0 && irq == 1'b0, "R6 done cleared",
              64'({done_pending, irq}), 64'd0);

        // R8: masking the completion cause
        done_mask = 1'b1;
        send(8'hA4); wait_posts(4);
        check(done_pending == 1'b1 && irq == 1'b0, "R8 done masked",
              64'({done_pending, irq}), 64'h2);
        @(negedge clk); done_mask = 1'b0;
        @(negedge clk);
        check(irq == 1'b1, "R8 unmask raises irq", 64'(irq), 64'd1);
        pulse_done_clr();

        // R2: request stalls
        stall_mode = 1'b1;
        send(8'h5C); send(8'h6D); send(8'hFF);
        wait_posts(7);
        stall_mode = 1'b0;
        check(expq.size() == 0, "R1 all stalled posts seen", 64'(expq.size()), 64'd0);

        // R4: wrap past the last word (host re-arms every word)
        for (int i = 0; i < DEPTH; i++) ring[i] = 32'h8000_0000;
        send(8'h07); send(8'h08); send(8'h09);
        wait_posts(10);
        check(ring[0] == 32'h0000_0008 && ring[1] == 32'h0000_0009, "R4 wrapped to 0",
              {ring[0], ring[1]}, {32'h8, 32'h9});
        pulse_done_clr();

        // R5 R7: host-owned word
        ring[exp_idx] = 32'h0000_0000;
        w0 = writes; r0 = reads;
        send(8'h5A);
        repeat (10) @(negedge clk);
        check(writes == w0, "R5 no write while host-owned", 64'(writes), 64'(w0));
        check(reads == r0 + 1, "R5 single read then park", 64'(reads), 64'(r0 + 1));
        check(err_status == 1'b1 && irq == 1'b1, "R7/R8 error raised",
              64'({err_status, irq}), 64'h3);
        check(evt_ready == 1'b0, "R5 event held", 64'(evt_ready), 64'd0);
        err_mask = 1'b1;
        repeat (3) @(negedge clk);
        check(err_status == 1'b1, "R7 sticky", 64'(err_status), 64'd1);
        pulse_err_clr();
        @(negedge clk);
        check(err_status == 1'b0 && irq == 1'b0, "R7 cleared", 64'({err_status, irq}), 64'd0);
        pulse_retry();
        repeat (5) @(negedge clk);
        check(reads == r0 + 2 && writes == w0, "R5 retry re-reads only",
              64'(reads), 64'(r0 + 2));
        check(err_status == 1'b1 && irq == 1'b0, "R8 error masked",
              64'({err_status, irq}), 64'h2);
        ring[exp_idx == 0 ? DEPTH - 1 : exp_idx - 1] = 32'h8000_0000;
        pulse_retry();
        wait_posts(w0 + 1);
        check(expq.size() == 0, "R5 held event posted at same index", 64'(expq.size()), 64'd0);
        err_mask = 1'b0;
        pulse_err_clr();
        pulse_done_clr();
        @(negedge clk);
        check({done_pending, err_status, irq} == 3'b000, "R6/R7 final clear",
              64'({done_pending, err_status, irq}), 64'd0);

        finished = 1'b1;
        summary();
    end
endmodule